// File: doc/BRIEF.md
# PWM Action-Qualifier Channel

One pulse-width-modulation channel for a digitally controlled power stage. A time-base counter runs against a period value, either counting up and wrapping (asymmetric carrier) or counting up then down (symmetric carrier). Six counter events are derived from it: counter at zero, counter at period, and the two compare values matched while counting up or while counting down. Each of the two generator outputs has its own action table that, per event, clears, sets, toggles or leaves that output alone. A one-cycle software force can override the tables.

The generated waveform then passes an optional dead-band stage that builds a complementary pair from generator A, with independent delays on the rising edge of the high side and on the rising edge of the low side. A fault stage sits last: latched one-shot trips that hold until cleared, and cycle-by-cycle trips that release at the next counter zero. While tripped, each output is driven high, low or released to high impedance as configured. A sync input loads a phase value into the counter so several channels can run interleaved from a master. The channel also emits an ADC start-of-conversion strobe on a compare-B match and an interrupt strobe on a period match.

The counter direction is a two-state machine, UP and DOWN. In up mode it stays in UP. In up/down mode it goes from UP to DOWN when the count reaches the period, and from DOWN to UP when the count reaches zero. Each dead-band delay path is a three-state machine. It goes from LO to WAIT when its input rises and the delay is non-zero, or from LO straight to HI when the delay is zero. It goes from WAIT to HI when the count expires, and from WAIT back to LO if the input falls first. It goes from HI to LO when the input falls.

Top module: `pwm_aq_channel`

## Requirements
- R1: With `cnt_updown`=0 the counter goes 0,1,…,`prd_val` and then returns to 0, one step per clock; `ctr_out` shows the count.
- R2: With `cnt_updown`=1 the counter rises to `prd_val` and then falls to 0, one step per clock. A count equal to `prd_val` is seen while rising, and a count of 0 is seen while falling.
- R3: A high `sync_in` makes the next count equal to the held phase value and sets the direction to rising, overriding normal counting.
- R4: The compare A, compare B and phase inputs are captured into held copies only on a clock where the count is 0; the events and the sync load use the held copies.
- R5: Each action table is 12 bits with 2 bits per event: bits 1:0 zero, 3:2 period, 5:4 compare A rising, 7:6 compare A falling, 9:8 compare B rising, 11:10 compare B falling. The codes are 00 no change, 01 clear, 10 set and 11 toggle. The generator output changes on the clock after the event cycle.
- R6: When several events with non-zero codes coincide, one action applies, chosen in this order from highest: the force input (`frc_a`/`frc_b`, same codes, 00 = none), compare A rising, compare A falling, compare B rising, compare B falling, period, zero.
- R7: With `db_en`=1, `pwm_a` is high exactly when generator A was high on each of the last `db_red`+1 clocks. `pwm_b` is high exactly when generator A was low on each of the last `db_fed`+1 clocks. With `db_en`=0 the generator outputs pass straight through.
- R8: `soc_pulse` is high for the clock after any cycle whose count equals held compare B. `irq_pulse` is high for the clock after any cycle whose count equals `prd_val`.
- R9: A trip line whose `trip_oneshot` bit is 1 latches the trip from the next clock. The trip stays latched until a clock with `trip_clr` high and no one-shot trip line active.
- R10: A trip line whose `trip_oneshot` bit is 0 latches a cycle-by-cycle trip from the next clock. This trip is released on a clock with the count at 0 and no such line active.
- R11: While either trip is latched, each output follows its trip action: 00 gives high impedance (`*_oe`=0, value 0), 01 drives high, 10 drives low, and 11 leaves the output unaffected. Otherwise `*_oe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_updown | input | 1 | 0 up count, 1 up/down count |
| prd_val | input | CW | Period value |
| cmpa_val | input | CW | Compare A value (held at zero) |
| cmpb_val | input | CW | Compare B value (held at zero) |
| phs_val | input | CW | Phase value (held at zero) |
| sync_in | input | 1 | Load held phase into counter |
| act_a | input | 12 | Action table for output A |
| act_b | input | 12 | Action table for output B |
| frc_a | input | 2 | Force action for A |
| frc_b | input | 2 | Force action for B |
| db_en | input | 1 | Dead-band enable |
| db_red | input | DW | Rising-edge delay of the high side |
| db_fed | input | DW | Rising-edge delay of the low side |
| trip_in | input | NT | Trip lines |
| trip_oneshot | input | NT | Per line: 1 one-shot, 0 cycle-by-cycle |
| trip_clr | input | 1 | Clear one-shot latch |
| trip_act_a | input | 2 | Tripped behaviour of A |
| trip_act_b | input | 2 | Tripped behaviour of B |
| ctr_out | output | CW | Current count |
| pwm_a | output | 1 | Output A value |
| pwm_a_oe | output | 1 | Output A drive enable |
| pwm_b | output | 1 | Output B value |
| pwm_b_oe | output | 1 | Output B drive enable |
| soc_pulse | output | 1 | ADC start-of-conversion strobe |
| irq_pulse | output | 1 | Period interrupt strobe |

## Verification
The properties assume that the period is at least 1 and that the period, the count mode and the two delays change only while reset is held. They also assume that the phase input never exceeds the period and that the trip lines are low during reset. The stimulus keeps to these limits by changing the carrier shape and the delays only inside a reset pulse. It draws each random phase from the range 0 to the current period and releases all trip lines before asserting reset. Within those limits the compare values, action tables, forces, sync pulses, trip lines and trip actions vary on every clock.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int NUM_EV = 6;
    localparam int EV_ZRO = 0;
    localparam int EV_PRD = 1;
    localparam int EV_CAU = 2;
    localparam int EV_CAD = 3;
    localparam int EV_CBU = 4;
    localparam int EV_CBD = 5;

    localparam logic [1:0] ACT_NONE = 2'b00;
    localparam logic [1:0] ACT_CLR  = 2'b01;
    localparam logic [1:0] ACT_SET  = 2'b10;
    localparam logic [1:0] ACT_TGL  = 2'b11;

    localparam logic [1:0] TRIP_HIZ  = 2'b00;
    localparam logic [1:0] TRIP_HIGH = 2'b01;
    localparam logic [1:0] TRIP_LOW  = 2'b10;

    // events listed from lowest to highest priority (R6)
    localparam int PRIO_ASC [NUM_EV] = '{EV_ZRO, EV_PRD, EV_CBD, EV_CBU, EV_CAD, EV_CAU};

    typedef enum logic {DIR_UP, DIR_DOWN} dir_t;
    typedef enum logic [1:0] {DLY_LO, DLY_WAIT, DLY_HI} dly_state_t;

    function automatic logic [1:0] pick_act(input logic [1:0] frc,
                                            input logic [2*NUM_EV-1:0] tbl,
                                            input logic [NUM_EV-1:0] ev);
        logic [1:0] sel;
        int e;
        sel = ACT_NONE;
        for (int i = 0; i < NUM_EV; i++) begin
            e = PRIO_ASC[i];
            if (ev[e] && tbl[2*e +: 2] != ACT_NONE) sel = tbl[2*e +: 2];
        end
        if (frc != ACT_NONE) sel = frc;
        return sel;
    endfunction

    function automatic logic apply_act(input logic cur, input logic [1:0] act);
        logic r;
        unique case (act)
            ACT_CLR: r = 1'b0;
            ACT_SET: r = 1'b1;
            ACT_TGL: r = ~cur;
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase import pwm_aq_pkg::*; #(
    parameter int CW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              updown,
    input  logic [CW-1:0]     prd,
    input  logic [CW-1:0]     cmpa_in,
    input  logic [CW-1:0]     cmpb_in,
    input  logic [CW-1:0]     phs_in,
    input  logic              sync,
    output logic [CW-1:0]     ctr,
    output logic [NUM_EV-1:0] ev,
    output logic              cmpb_hit
);
    localparam logic [CW-1:0] ONE = CW'(1);

    dir_t          dir_q, dir_d;
    logic [CW-1:0] ctr_q, ctr_d, cmpa_q, cmpb_q, phs_q;
    logic          at_zero, at_prd, going_up;

    assign at_zero  = (ctr_q == '0);
    assign at_prd   = (ctr_q == prd);
    assign going_up = (dir_q == DIR_UP);

    // state register; held copies load at zero (R4)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q  <= '0;
            dir_q  <= DIR_UP;
            cmpa_q <= '0;
            cmpb_q <= '0;
            phs_q  <= '0;
        end else begin
            ctr_q <= ctr_d;
            dir_q <= dir_d;
            if (at_zero) begin
                cmpa_q <= cmpa_in;
                cmpb_q <= cmpb_in;
                phs_q  <= phs_in;
            end
        end
    end

    // next count and direction (R1, R2, R3)
    always_comb begin
        ctr_d = ctr_q;
        dir_d = dir_q;
        if (sync) begin
            ctr_d = phs_q;
            dir_d = DIR_UP;
        end else if (!updown) begin
            ctr_d = at_prd ? '0 : ctr_q + ONE;
            dir_d = DIR_UP;
        end else begin
            unique case (dir_q)
                DIR_UP: begin
                    if (at_prd) begin
                        dir_d = DIR_DOWN;
                        ctr_d = ctr_q - ONE;
                    end else begin
                        ctr_d = ctr_q + ONE;
                    end
                end
                DIR_DOWN: begin
                    if (at_zero) begin
                        dir_d = DIR_UP;
                        ctr_d = ctr_q + ONE;
                    end else begin
                        ctr_d = ctr_q - ONE;
                    end
                end
            endcase
        end
    end

    // event outputs
    always_comb begin
        ev         = '0;
        ev[EV_ZRO] = at_zero;
        ev[EV_PRD] = at_prd;
        ev[EV_CAU] = (ctr_q == cmpa_q) && going_up;
        ev[EV_CAD] = (ctr_q == cmpa_q) && !going_up;
        ev[EV_CBU] = (ctr_q == cmpb_q) && going_up;
        ev[EV_CBD] = (ctr_q == cmpb_q) && !going_up;
        cmpb_hit   = (ctr_q == cmpb_q);
    end

    assign ctr = ctr_q;

endmodule

// File: rtl/pwm_aq_unit.sv
module pwm_aq_unit import pwm_aq_pkg::*; (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EV-1:0]   ev,
    input  logic [2*NUM_EV-1:0] tbl,
    input  logic [1:0]          frc,
    output logic                q
);
    logic q_d;

    // one action per clock, chosen by priority (R5, R6)
    always_comb q_d = apply_act(q, pick_act(frc, tbl, ev));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_d;
    end

endmodule

// File: rtl/pwm_edge_delay.sv
module pwm_edge_delay import pwm_aq_pkg::*; #(
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    input  logic [DW-1:0] dly,
    output logic          dout
);
    localparam logic [DW-1:0] ONE = DW'(1);

    dly_state_t    st_q, st_d;
    logic [DW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DLY_LO;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // rising edge held back by dly clocks, falling edge passes (R7)
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            DLY_LO: begin
                if (din) begin
                    if (dly == '0) begin
                        st_d = DLY_HI;
                    end else begin
                        st_d  = DLY_WAIT;
                        cnt_d = dly - ONE;
                    end
                end
            end
            DLY_WAIT: begin
                if (!din)              st_d = DLY_LO;
                else if (cnt_q == '0)  st_d = DLY_HI;
                else                   cnt_d = cnt_q - ONE;
            end
            DLY_HI: begin
                if (!din) st_d = DLY_LO;
            end
            default: st_d = DLY_LO;
        endcase
    end

    assign dout = (st_q == DLY_HI);

endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel import pwm_aq_pkg::*; #(
    parameter int CW = 12,
    parameter int DW = 6,
    parameter int NT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_updown,
    input  logic [CW-1:0]       prd_val,
    input  logic [CW-1:0]       cmpa_val,
    input  logic [CW-1:0]       cmpb_val,
    input  logic [CW-1:0]       phs_val,
    input  logic                sync_in,
    input  logic [2*NUM_EV-1:0] act_a,
    input  logic [2*NUM_EV-1:0] act_b,
    input  logic [1:0]          frc_a,
    input  logic [1:0]          frc_b,
    input  logic                db_en,
    input  logic [DW-1:0]       db_red,
    input  logic [DW-1:0]       db_fed,
    input  logic [NT-1:0]       trip_in,
    input  logic [NT-1:0]       trip_oneshot,
    input  logic                trip_clr,
    input  logic [1:0]          trip_act_a,
    input  logic [1:0]          trip_act_b,
    output logic [CW-1:0]       ctr_out,
    output logic                pwm_a,
    output logic                pwm_a_oe,
    output logic                pwm_b,
    output logic                pwm_b_oe,
    output logic                soc_pulse,
    output logic                irq_pulse
);
    localparam int TW = 2 * NUM_EV;

    logic [NUM_EV-1:0]   tb_ev;
    logic                cmpb_hit;
    logic [1:0][TW-1:0]  tbl_v;
    logic [1:0][1:0]     frc_v;
    logic [1:0][1:0]     tact_v;
    logic [1:0][DW-1:0]  dly_v;
    logic [1:0]          aq_q, db_in, db_q, gen_v, out_v, oe_v;
    logic                os_q, cbc_q, os_hit, cbc_hit, tripped;

    assign tbl_v  = {act_b, act_a};
    assign frc_v  = {frc_b, frc_a};
    assign tact_v = {trip_act_b, trip_act_a};
    assign dly_v  = {db_fed, db_red};
    assign db_in  = {~aq_q[0], aq_q[0]};

    pwm_timebase #(.CW(CW)) u_tb (
        .clk(clk), .rst_n(rst_n), .updown(cnt_updown), .prd(prd_val),
        .cmpa_in(cmpa_val), .cmpb_in(cmpb_val), .phs_in(phs_val),
        .sync(sync_in), .ctr(ctr_out), .ev(tb_ev), .cmpb_hit(cmpb_hit)
    );

    for (genvar g = 0; g < 2; g++) begin : g_path
        pwm_aq_unit u_aq (
            .clk(clk), .rst_n(rst_n), .ev(tb_ev), .tbl(tbl_v[g]),
            .frc(frc_v[g]), .q(aq_q[g])
        );
        pwm_edge_delay #(.DW(DW)) u_dly (
            .clk(clk), .rst_n(rst_n), .din(db_in[g]), .dly(dly_v[g]),
            .dout(db_q[g])
        );
        assign gen_v[g] = db_en ? db_q[g] : aq_q[g];

        // trip override (R11)
        always_comb begin
            out_v[g] = gen_v[g];
            oe_v[g]  = 1'b1;
            if (tripped) begin
                unique case (tact_v[g])
                    TRIP_HIZ:  begin out_v[g] = 1'b0; oe_v[g] = 1'b0; end
                    TRIP_HIGH: out_v[g] = 1'b1;
                    TRIP_LOW:  out_v[g] = 1'b0;
                    default:   out_v[g] = gen_v[g];
                endcase
            end
        end
    end

    assign os_hit  = |(trip_in & trip_oneshot);
    assign cbc_hit = |(trip_in & ~trip_oneshot);
    assign tripped = os_q | cbc_q;

    // trip latches (R9, R10) and strobes (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q      <= 1'b0;
            cbc_q     <= 1'b0;
            soc_pulse <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            if (os_hit)        os_q <= 1'b1;
            else if (trip_clr) os_q <= 1'b0;
            if (cbc_hit)             cbc_q <= 1'b1;
            else if (tb_ev[EV_ZRO])  cbc_q <= 1'b0;
            soc_pulse <= cmpb_hit;
            irq_pulse <= tb_ev[EV_PRD];
        end
    end

    assign pwm_a    = out_v[0];
    assign pwm_b    = out_v[1];
    assign pwm_a_oe = oe_v[0];
    assign pwm_b_oe = oe_v[1];

endmodule

// File: rtl/pwm_aq_checker.sv
module pwm_aq_checker #(
    parameter int CW = 12,
    parameter int NT = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_updown,
    input logic [CW-1:0] prd_val,
    input logic [CW-1:0] ctr_out,
    input logic          sync_in,
    input logic          irq_pulse,
    input logic          db_en,
    input logic          tripped,
    input logic          pwm_a,
    input logic          pwm_b,
    input logic          pwm_b_oe,
    input logic [NT-1:0] trip_in,
    input logic [NT-1:0] trip_oneshot,
    input logic [1:0]    trip_act_a,
    input logic [1:0]    trip_act_b
);
    localparam logic [CW-1:0] ONE = CW'(1);

    // count stays within period in both modes (also R2)
    assert_ctr_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_out <= prd_val)
        else $error("count above period");

    assert_up_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!sync_in) && $past(!cnt_updown) && !cnt_updown)
        |-> (ctr_out == '0 || ctr_out == $past(ctr_out) + ONE))
        else $error("up count step wrong");

    assert_irq_on_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(ctr_out) == $past(prd_val)))
        else $error("interrupt without period match");

    assert_db_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (db_en && !tripped) |-> !(pwm_a && pwm_b))
        else $error("both dead-band outputs high");

    assert_oneshot_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(|(trip_in & trip_oneshot)) && trip_act_a == 2'b01) |-> pwm_a)
        else $error("one-shot trip did not force A high");

    assert_cbc_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(|(trip_in & ~trip_oneshot)) && trip_act_b == 2'b00) |-> !pwm_b_oe)
        else $error("cycle trip did not release B (R11)");

endmodule

bind pwm_aq_channel pwm_aq_checker #(.CW(CW), .NT(NT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_updown(cnt_updown), .prd_val(prd_val),
    .ctr_out(ctr_out), .sync_in(sync_in), .irq_pulse(irq_pulse),
    .db_en(db_en), .tripped(tripped), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .pwm_b_oe(pwm_b_oe), .trip_in(trip_in), .trip_oneshot(trip_oneshot),
    .trip_act_a(trip_act_a), .trip_act_b(trip_act_b)
);

// File: tb/sim_pwm_aq_channel.sv
module sim_pwm_aq_channel;
    localparam int CW = 12;
    localparam int DW = 6;
    localparam int NT = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cnt_updown = 1'b0;
    logic [CW-1:0] prd_val = 12'd9, cmpa_val = '0, cmpb_val = '0, phs_val = '0;
    logic          sync_in = 1'b0;
    logic [11:0]   act_a = '0, act_b = '0;
    logic [1:0]    frc_a = '0, frc_b = '0;
    logic          db_en = 1'b0;
    logic [DW-1:0] db_red = '0, db_fed = '0;
    logic [NT-1:0] trip_in = '0, trip_oneshot = '0;
    logic          trip_clr = 1'b0;
    logic [1:0]    trip_act_a = 2'b11, trip_act_b = 2'b11;
    logic [CW-1:0] ctr_out;
    logic          pwm_a, pwm_a_oe, pwm_b, pwm_b_oe, soc_pulse, irq_pulse;

    pwm_aq_channel #(.CW(CW), .DW(DW), .NT(NT)) u0 (.*);

    int n_vec = 0;
    int n_bad = 0;
    logic done = 1'b0;

    // behavioural reference state
    int         m_ctr, m_cmpa, m_cmpb, m_phs;
    logic       m_up, m_aqa, m_aqb, m_soc, m_irq, m_os, m_cbc;
    logic [63:0] m_ha, m_hb;

    function automatic logic [1:0] m_pick(logic [1:0] frc, logic [11:0] t, logic [5:0] ev);
        if (frc != 0) return frc;                 // R6 force first
        if (ev[2] && t[5:4]   != 0) return t[5:4];
        if (ev[3] && t[7:6]   != 0) return t[7:6];
        if (ev[4] && t[9:8]   != 0) return t[9:8];
        if (ev[5] && t[11:10] != 0) return t[11:10];
        if (ev[1] && t[3:2]   != 0) return t[3:2];
        if (ev[0] && t[1:0]   != 0) return t[1:0];
        return 2'b00;
    endfunction

    function automatic logic m_apply(logic cur, logic [1:0] a);
        if (a == 2'b01) return 1'b0;
        if (a == 2'b10) return 1'b1;
        if (a == 2'b11) return ~cur;
        return cur;
    endfunction

    function automatic logic m_all(logic [63:0] h, int d);
        for (int k = 0; k <= d; k++) if (!h[k]) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin : model
        logic [5:0] ev;
        int p;
        if (!rst_n) begin
            m_ctr = 0; m_up = 1; m_cmpa = 0; m_cmpb = 0; m_phs = 0;
            m_aqa = 0; m_aqb = 0; m_soc = 0; m_irq = 0; m_os = 0; m_cbc = 0;
            m_ha = '0; m_hb = '0;
        end else begin
            p = int'(prd_val);
            ev[0] = (m_ctr == 0);
            ev[1] = (m_ctr == p);
            ev[2] = (m_ctr == m_cmpa) && m_up;
            ev[3] = (m_ctr == m_cmpa) && !m_up;
            ev[4] = (m_ctr == m_cmpb) && m_up;
            ev[5] = (m_ctr == m_cmpb) && !m_up;
            m_ha = {m_ha[62:0], m_aqa};
            m_hb = {m_hb[62:0], ~m_aqa};
            m_aqa = m_apply(m_aqa, m_pick(frc_a, act_a, ev));
            m_aqb = m_apply(m_aqb, m_pick(frc_b, act_b, ev));
            m_soc = (m_ctr == m_cmpb);
            m_irq = ev[1];
            if (|(trip_in & trip_oneshot)) m_os = 1;
            else if (trip_clr)             m_os = 0;
            if (|(trip_in & ~trip_oneshot)) m_cbc = 1;
            else if (ev[0])                 m_cbc = 0;
            if (sync_in) begin
                m_ctr = m_phs; m_up = 1;
            end else if (!cnt_updown) begin
                m_ctr = ev[1] ? 0 : m_ctr + 1; m_up = 1;
            end else if (m_up) begin
                if (ev[1]) begin m_up = 0; m_ctr = m_ctr - 1; end
                else m_ctr = m_ctr + 1;
            end else begin
                if (ev[0]) begin m_up = 1; m_ctr = m_ctr + 1; end
                else m_ctr = m_ctr - 1;
            end
            if (ev[0]) begin
                m_cmpa = int'(cmpa_val); m_cmpb = int'(cmpb_val); m_phs = int'(phs_val);
            end
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic trip_drive(logic [1:0] m, logic nrm, logic trp, output logic v, output logic oe);
        v = nrm; oe = 1'b1;
        if (trp) begin
            if (m == 2'b00) begin v = 1'b0; oe = 1'b0; end
            else if (m == 2'b01) v = 1'b1;
            else if (m == 2'b10) v = 1'b0;
        end
    endtask

    task automatic compare();
        logic na, nb, ea, eb, eoa, eob, trp;
        string tg;
        trp = m_os | m_cbc;
        na = db_en ? m_all(m_ha, int'(db_red)) : m_aqa;
        nb = db_en ? m_all(m_hb, int'(db_fed)) : m_aqb;
        trip_drive(trip_act_a, na, trp, ea, eoa);
        trip_drive(trip_act_b, nb, trp, eb, eob);
        tg = trp ? (m_os ? "R9" : "R10") : (db_en ? "R7" : "R5");
        chk(cnt_updown ? "R2" : "R1", "ctr_out", 32'(ctr_out), 32'(m_ctr));
        chk(tg, "pwm_a", 32'(pwm_a), 32'(ea));
        chk(tg, "pwm_b", 32'(pwm_b), 32'(eb));
        chk("R11", "pwm_a_oe", 32'(pwm_a_oe), 32'(eoa));
        chk("R11", "pwm_b_oe", 32'(pwm_b_oe), 32'(eob));
        chk("R8", "soc_pulse", 32'(soc_pulse), 32'(m_soc));
        chk("R8", "irq_pulse", 32'(irq_pulse), 32'(m_irq));
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic seg_reset(logic mode, int prd, int red, int fed);
        @(negedge clk);
        trip_in = '0; sync_in = 0; frc_a = 0; frc_b = 0; trip_clr = 0;
        rst_n = 0;
        cnt_updown = mode; prd_val = CW'(prd);
        db_red = DW'(red); db_fed = DW'(fed);
        cmpa_val = '0; cmpb_val = '0; phs_val = '0;
        step();
        rst_n = 1;
    endtask

    task automatic wiggle(bit cmp, bit syn, bit act, bit frc, bit trp);
        int p;
        p = int'(prd_val);
        if (cmp) begin
            cmpa_val = CW'($urandom_range(p, 0));
            cmpb_val = CW'($urandom_range(p, 0));
            phs_val  = CW'($urandom_range(p, 0));
        end
        if (syn) sync_in = ($urandom_range(7, 0) == 0);
        if (act) begin
            act_a = 12'($urandom);
            act_b = 12'($urandom);
        end
        if (frc) begin
            frc_a = ($urandom_range(3, 0) == 0) ? 2'($urandom) : 2'b00;
            frc_b = ($urandom_range(3, 0) == 0) ? 2'($urandom) : 2'b00;
        end
        if (trp) begin
            trip_in  = ($urandom_range(15, 0) == 0) ? NT'(1 << $urandom_range(NT-1, 0)) : '0;
            trip_clr = ($urandom_range(9, 0) == 0);
            if ($urandom_range(31, 0) == 0) begin
                trip_oneshot = NT'($urandom);
                trip_act_a   = 2'($urandom);
                trip_act_b   = 2'($urandom);
            end
        end
    endtask

    initial begin
        // reset state
        seg_reset(0, 9, 0, 0);
        rst_n = 0;
        step();
        chk("R1", "reset ctr_out", 32'(ctr_out), 32'd0);
        chk("R5", "reset pwm_a", 32'(pwm_a), 32'd0);
        rst_n = 1;

        // R1 R5 R8: up count, A set at zero and cleared at compare A rising, B toggles at period
        seg_reset(0, 9, 0, 0);
        cmpa_val = 12'd3; cmpb_val = 12'd6;
        act_a = 12'h012; act_b = 12'h00C;
        repeat (40) step();

        // R2 R7: up/down, dead band on
        seg_reset(1, 10, 2, 3);
        db_en = 1; cmpa_val = 12'd4; cmpb_val = 12'd7;
        act_a = 12'h060; act_b = 12'h900;
        repeat (60) step();

        // R4: compare values change every clock, only the held copies act
        seg_reset(0, 12, 0, 0);
        db_en = 0;
        for (int i = 0; i < 200; i++) begin step(); wiggle(1, 0, 0, 0, 0); end

        // R3: sync pulses with random phase, up/down
        seg_reset(1, 7, 1, 1);
        for (int i = 0; i < 200; i++) begin step(); wiggle(1, 1, 0, 0, 0); end

        // R6: coinciding events and forces
        seg_reset(0, 5, 0, 0);
        for (int i = 0; i < 300; i++) begin
            step();
            wiggle(0, 0, 1, 1, 0);
            cmpa_val = ($urandom_range(1, 0) == 0) ? 12'd0 : 12'd5;
            cmpb_val = ($urandom_range(1, 0) == 0) ? 12'd0 : 12'd5;
        end

        // R9 R10 R11: trips in both modes
        for (int m = 0; m < 2; m++) begin
            seg_reset(1'(m), 15, 2, 2);
            trip_oneshot = 6'b000111; trip_act_a = 2'b01; trip_act_b = 2'b00;
            for (int i = 0; i < 400; i++) begin step(); wiggle(1, 0, 1, 0, 1); end
            trip_in = '0;
        end

        // everything together
        for (int s = 0; s < 6; s++) begin
            seg_reset(1'($urandom), $urandom_range(40, 1),
                      $urandom_range(7, 0), $urandom_range(7, 0));
            for (int i = 0; i < 1500; i++) begin
                step();
                wiggle(1, 1, 1, 1, 1);
                if ($urandom_range(63, 0) == 0) db_en = ~db_en;
            end
            trip_in = '0;
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule